// File: doc/BRIEF.md
# Filtered Event Counter

This block counts transitions on an external event line. The line is first brought into the clock domain by a short synchronizer. It can then pass through a sampled noise eliminator that ignores brief glitches. Finally an edge detector, set to rising or falling edges, advances an 8-bit counter. The counter wraps from 0xFF to 0x00. When it wraps, a sticky overflow flag is set and an interrupt request pulse is sent out.

Software controls the block through a simple write port that carries an address, a write enable and a data byte. A mode byte holds three controls: a run enable that freezes the count when it is cleared, the edge polarity, and a start command. The start command clears the count and the flag and then reads back as zero by itself. A gate byte switches the noise eliminator in or out. A third address issues a start on its own, without touching the mode bits. The count, the flag and both control bytes are always visible on output ports.

Top module: `evtCounter`

## Requirements
- R1: With run enable set (mode bit 4 = 1) and the noise eliminator off, each selected edge of `evtIn` raises `count` by exactly one.
- R2: A start command clears `count` and `ovfFlag` on the clock edge that follows the write. A start command is a write to address 0 with data bit 3 = 1, or any write to address 2. Mode bit 3 reads 1 for that one cycle and 0 afterwards.
- R3: With mode bit 4 = 0, edges on `evtIn` leave `count` unchanged. Setting the bit again resumes counting from the held value.
- R4: Mode bit 2 selects the counted edge: 0 counts low-to-high transitions and 1 counts high-to-low transitions.
- R5: A counted edge at 0xFF takes `count` to 0x00 and sets `ovfFlag`. The flag stays set while counting continues, until a start command clears it.
- R6: `irqPulse` is high for exactly one cycle, on the same edge at which the count wraps, and never at any other time.
- R7: Gate bit 0 = 1 enables the noise eliminator. It samples the line once every four clocks and passes a new level only after two successive samples agree on it. High pulses of 4 clocks or fewer are never counted, and pulses of 8 clocks or more are always counted. Gate bit 0 = 0 uses the synchronized line directly.
- R8: A write to address 2 starts the counter without changing any mode bit. Writes to address 3 change no register and no output.
- R9: When a start clear and a counted edge fall on the same cycle, the clear wins and the edge is lost.
- R10: After reset, `count`, `ovfFlag`, `irqPulse`, `modeRd` and `gateRd` are all zero.
- R11: `modeRd` returns the last byte written to address 0, with bit 3 shown as described in R2. `gateRd` returns gate bit 0 in bit 0, and its other bits read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main clock |
| rstN | input | 1 | Asynchronous active-low reset |
| evtIn | input | 1 | External event line (asynchronous) |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Write address: 0 mode, 1 gate, 2 start alias, 3 unused |
| wrData | input | 8 | Write data |
| count | output | 8 | Current event count |
| ovfFlag | output | 1 | Sticky overflow flag |
| irqPulse | output | 1 | One-cycle interrupt request at overflow |
| modeRd | output | 8 | Mode byte readback |
| gateRd | output | 8 | Gate byte readback |

## Verification
The hardest case to reach from the ports is R9. The start clear has to land on the exact clock edge at which a synchronized edge would be counted. The bench raises `evtIn` at a falling clock edge and writes to the start alias at the next falling edge. This puts the pending clear and the edge detector's output on the same rising edge, two synchronizer stages after the input change. The count must then read zero and stay zero. The filter limits in R7 are reached by driving high pulses of 3, 4, 8, 12 and 16 clocks against the free-running quarter-rate sampler. R5 and R6 are reached by counting 258 edges through a wrap.

// File: rtl/evtCounterPkg.sv
package evtCounterPkg;

  localparam int REG_W = 8;

  localparam logic [1:0] ADDR_MODE  = 2'd0;
  localparam logic [1:0] ADDR_GATE  = 2'd1;
  localparam logic [1:0] ADDR_START = 2'd2;

  localparam int BIT_EDGE   = 2;
  localparam int BIT_START  = 3;
  localparam int BIT_RUN    = 4;
  localparam int BIT_SAMPLE = 0;

  typedef struct packed {
    logic clear;
    logic countEn;
    logic fallSel;
    logic sampleEn;
  } ctlStrobes_t;

endpackage

// File: rtl/evtCounterCtrl.sv
module evtCounterCtrl
  import evtCounterPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [REG_W-1:0] wrData,
  output ctlStrobes_t      ctl,
  output logic [REG_W-1:0] modeRd,
  output logic [REG_W-1:0] gateRd
);

  localparam logic [REG_W-1:0] START_MASK = REG_W'(1) << BIT_START;

  logic [REG_W-1:0] modeReg;
  logic             startReq;
  logic             sampleReg;
  logic             modeWr;
  logic             gateWr;
  logic             startWr;

  always_comb begin
    modeWr  = wrEn && (wrAddr == ADDR_MODE);
    gateWr  = wrEn && (wrAddr == ADDR_GATE);
    startWr = (modeWr && wrData[BIT_START]) || (wrEn && (wrAddr == ADDR_START));
  end

  // The start bit is never stored; a pending request stands in for it for one cycle.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeReg   <= '0;
      startReq  <= 1'b0;
      sampleReg <= 1'b0;
    end else begin
      startReq <= startWr;
      if (modeWr) modeReg <= wrData & ~START_MASK;
      if (gateWr) sampleReg <= wrData[BIT_SAMPLE];
    end
  end

  always_comb begin
    ctl.clear    = startReq;
    ctl.countEn  = modeReg[BIT_RUN];
    ctl.fallSel  = modeReg[BIT_EDGE];
    ctl.sampleEn = sampleReg;
    modeRd       = modeReg | (startReq ? START_MASK : '0);
    gateRd       = '0;
    gateRd[BIT_SAMPLE] = sampleReg;
  end

endmodule

// File: rtl/evtNoiseFilter.sv
module evtNoiseFilter #(
  parameter int PRESCALE = 4,
  parameter int AGREE    = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);

  localparam int PS_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam int HIST_W = (AGREE > 1) ? AGREE - 1 : 1;
  localparam logic [PS_W-1:0] PS_LAST = PS_W'(PRESCALE - 1);

  logic [PS_W-1:0]   prescale;
  logic              sampleStb;
  logic [HIST_W-1:0] hist;
  logic [AGREE-1:0]  window;
  logic              allHigh;
  logic              allLow;

  always_comb begin
    sampleStb = (prescale == PS_LAST);
    window    = {hist, din};
    allHigh   = &window;
    allLow    = ~|window;
  end

  // Free-running divider; it is not reset by start so sampling phase is arbitrary.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prescale <= '0;
    end else if (sampleStb) begin
      prescale <= '0;
    end else begin
      prescale <= prescale + PS_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hist <= '0;
      dout <= 1'b0;
    end else if (sampleStb) begin
      hist <= window[HIST_W-1:0];
      if (allHigh) dout <= 1'b1;
      else if (allLow) dout <= 1'b0;
    end
  end

endmodule

// File: rtl/evtCounterPath.sv
module evtCounterPath
  import evtCounterPkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int PRESCALE    = 4,
  parameter int AGREE       = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             evtIn,
  input  ctlStrobes_t      ctl,
  output logic [CNT_W-1:0] count,
  output logic             ovfFlag,
  output logic             irqPulse
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [SYNC_STAGES-1:0] syncChain;
  logic                   syncLvl;
  logic                   filtLvl;
  logic                   selLvl;
  logic                   prevLvl;
  logic                   riseSeen;
  logic                   fallSeen;
  logic                   edgeHit;
  logic                   step;

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain[s] <= 1'b0;
        else if (s == 0) syncChain[s] <= evtIn;
        else syncChain[s] <= syncChain[(s > 0) ? s - 1 : 0];
      end
    end
  endgenerate

  assign syncLvl = syncChain[SYNC_STAGES-1];

  evtNoiseFilter #(
    .PRESCALE(PRESCALE),
    .AGREE   (AGREE)
  ) u_filter (
    .clk (clk),
    .rstN(rstN),
    .din (syncLvl),
    .dout(filtLvl)
  );

  always_comb begin
    selLvl   = ctl.sampleEn ? filtLvl : syncLvl;
    riseSeen = selLvl & ~prevLvl;
    fallSeen = ~selLvl & prevLvl;
    edgeHit  = ctl.fallSel ? fallSeen : riseSeen;
    step     = edgeHit && ctl.countEn && !ctl.clear;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevLvl <= 1'b0;
    else prevLvl <= selLvl;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count    <= '0;
      ovfFlag  <= 1'b0;
      irqPulse <= 1'b0;
    end else begin
      irqPulse <= 1'b0;
      if (ctl.clear) begin
        count   <= '0;
        ovfFlag <= 1'b0;
      end else if (step) begin
        count <= count + CNT_W'(1);
        if (count == CNT_MAX) begin
          ovfFlag  <= 1'b1;
          irqPulse <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/evtCounter.sv
module evtCounter
  import evtCounterPkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int PRESCALE    = 4,
  parameter int AGREE       = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             evtIn,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [REG_W-1:0] wrData,
  output logic [CNT_W-1:0] count,
  output logic             ovfFlag,
  output logic             irqPulse,
  output logic [REG_W-1:0] modeRd,
  output logic [REG_W-1:0] gateRd
);

  ctlStrobes_t ctlStb;

  evtCounterCtrl u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .wrEn  (wrEn),
    .wrAddr(wrAddr),
    .wrData(wrData),
    .ctl   (ctlStb),
    .modeRd(modeRd),
    .gateRd(gateRd)
  );

  evtCounterPath #(
    .CNT_W      (CNT_W),
    .SYNC_STAGES(SYNC_STAGES),
    .PRESCALE   (PRESCALE),
    .AGREE      (AGREE)
  ) u_path (
    .clk     (clk),
    .rstN    (rstN),
    .evtIn   (evtIn),
    .ctl     (ctlStb),
    .count   (count),
    .ovfFlag (ovfFlag),
    .irqPulse(irqPulse)
  );

endmodule

// File: rtl/evtCounterChk.sv
module evtCounterChk
  import evtCounterPkg::*;
#(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic [1:0]       wrAddr,
  input logic [REG_W-1:0] wrData,
  input logic [CNT_W-1:0] count,
  input logic             ovfFlag,
  input logic             irqPulse,
  input logic [REG_W-1:0] modeRd,
  input logic             clearStb
);

  logic startWr;
  assign startWr = wrEn && ((wrAddr == ADDR_START) ||
                            ((wrAddr == ADDR_MODE) && wrData[BIT_START]));

  p_start_clears_r2: assert property (@(posedge clk) disable iff (!rstN)
    startWr |=> ##1 (count == '0 && !ovfFlag));

  p_start_self_clear_r2: assert property (@(posedge clk) disable iff (!rstN)
    (modeRd[BIT_START] && !startWr) |=> !modeRd[BIT_START]);

  p_hold_disabled_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!modeRd[BIT_RUN] && !clearStb) |=> $stable(count));

  p_single_step_r1: assert property (@(posedge clk) disable iff (!rstN)
    !clearStb |=> (count == $past(count) || count == $past(count) + CNT_W'(1)));

  p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !clearStb) |=> ovfFlag);

  p_irq_wrap_r6: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> (count == '0 && ovfFlag));

  p_irq_one_cycle_r6: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |=> !irqPulse);

  p_clear_beats_edge_r9: assert property (@(posedge clk) disable iff (!rstN)
    clearStb |=> (count == '0));

endmodule

bind evtCounter evtCounterChk #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .wrEn    (wrEn),
  .wrAddr  (wrAddr),
  .wrData  (wrData),
  .count   (count),
  .ovfFlag (ovfFlag),
  .irqPulse(irqPulse),
  .modeRd  (modeRd),
  .clearStb(ctlStb.clear)
);

// File: tb/evtCounter_tb.sv
module evtCounter_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       evtIn = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] wrAddr = 2'd0;
  logic [7:0] wrData = 8'd0;
  logic [7:0] count;
  logic       ovfFlag;
  logic       irqPulse;
  logic [7:0] modeRd;
  logic [7:0] gateRd;

  int errCnt = 0;
  int chkCnt = 0;
  int irqSeen = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  evtCounter u_dut (
    .clk(clk), .rstN(rstN), .evtIn(evtIn), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .count(count), .ovfFlag(ovfFlag), .irqPulse(irqPulse),
    .modeRd(modeRd), .gateRd(gateRd)
  );

  always @(negedge clk) if (irqPulse) irqSeen++;

  typedef struct packed {
    logic       samp;
    logic       fall;
    logic [7:0] width;
    logic [7:0] gap;
    logic [7:0] nPulse;
    logic [7:0] expCnt;
  } vec_t;

  // R1 raw rising, R4 falling, R7 filter pass/reject
  localparam vec_t VECS [8] = '{
    '{1'b0, 1'b0, 8'd2,  8'd3,  8'd5, 8'd5},
    '{1'b0, 1'b1, 8'd2,  8'd3,  8'd7, 8'd7},
    '{1'b0, 1'b0, 8'd1,  8'd3,  8'd4, 8'd4},
    '{1'b1, 1'b0, 8'd12, 8'd12, 8'd3, 8'd3},
    '{1'b1, 1'b0, 8'd4,  8'd12, 8'd6, 8'd0},
    '{1'b1, 1'b1, 8'd3,  8'd12, 8'd5, 8'd0},
    '{1'b1, 1'b1, 8'd8,  8'd12, 8'd4, 8'd4},
    '{1'b1, 1'b0, 8'd16, 8'd16, 8'd2, 8'd2}
  };

  task automatic check(input string req, input int act, input int exp);
    chkCnt++;
    if (act != exp) begin
      errCnt++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = 8'd0; wrAddr = 2'd0;
  endtask

  task automatic pulses(input int n, input int width, input int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); evtIn = 1'b1;
      repeat (width) @(negedge clk);
      evtIn = 1'b0;
      repeat (gap) @(negedge clk);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  endtask

  initial begin
    #400000;
    if (!done) begin
      errCnt++; chkCnt++;
      $display("FAIL watchdog: actual=hung expected=finished");
      report();
    end
  end

  initial begin
    int irqBase;
    idle(3);
    // R10 reset state
    check("R10 count", count, 0);
    check("R10 ovfFlag", ovfFlag, 0);
    check("R10 irqPulse", irqPulse, 0);
    check("R10 modeRd", modeRd, 0);
    check("R10 gateRd", gateRd, 0);
    rstN = 1'b1;
    idle(3);

    // R11 readback
    writeReg(2'd0, 8'hE5);
    check("R11 modeRd", modeRd, 8'hE5);
    writeReg(2'd1, 8'hFF);
    check("R11 gateRd", gateRd, 8'h01);
    writeReg(2'd1, 8'h00);

    // vector table: R1, R4, R7
    for (int v = 0; v < 8; v++) begin
      writeReg(2'd1, {7'd0, VECS[v].samp});
      writeReg(2'd0, {3'b000, 1'b1, 1'b1, VECS[v].fall, 2'b00});
      idle(4);
      pulses(VECS[v].nPulse, VECS[v].width, VECS[v].gap);
      idle(30);
      check($sformatf("R1/R4/R7 vector %0d count", v), count, VECS[v].expCnt);
    end
    writeReg(2'd1, 8'h00);

    // R2 start self-clear and clearing
    writeReg(2'd0, 8'h18);
    check("R2 start bit visible", modeRd, 8'h18);
    @(negedge clk);
    check("R2 start bit cleared", modeRd, 8'h10);
    check("R2 count cleared", count, 0);

    // R3 hold while disabled
    idle(4);
    pulses(3, 2, 3);
    idle(10);
    check("R3 counted before hold", count, 3);
    writeReg(2'd0, 8'h00);
    pulses(4, 2, 3);
    idle(10);
    check("R3 held while disabled", count, 3);
    writeReg(2'd0, 8'h10);
    pulses(2, 2, 3);
    idle(10);
    check("R3 resumed", count, 5);

    // R8 start alias and unused address
    writeReg(2'd3, 8'hFF);
    idle(2);
    check("R8 addr3 count", count, 5);
    check("R8 addr3 modeRd", modeRd, 8'h10);
    check("R8 addr3 gateRd", gateRd, 8'h00);
    writeReg(2'd0, 8'h14);
    writeReg(2'd2, 8'h00);
    idle(2);
    check("R8 alias clears count", count, 0);
    check("R8 alias keeps mode", modeRd, 8'h14);

    // R5/R6 overflow
    writeReg(2'd0, 8'h18);
    idle(4);
    irqBase = irqSeen;
    pulses(255, 2, 2);
    idle(10);
    check("R5 count at max", count, 8'hFF);
    check("R5 flag before wrap", ovfFlag, 0);
    check("R6 no irq before wrap", irqSeen - irqBase, 0);
    pulses(1, 2, 2);
    idle(10);
    check("R5 wrapped count", count, 0);
    check("R5 flag set", ovfFlag, 1);
    check("R6 one irq pulse", irqSeen - irqBase, 1);
    pulses(2, 2, 2);
    idle(10);
    check("R5 keeps counting", count, 2);
    check("R5 flag sticky", ovfFlag, 1);
    check("R6 still one irq", irqSeen - irqBase, 1);
    writeReg(2'd2, 8'h00);
    idle(2);
    check("R5 start clears flag", ovfFlag, 0);

    // R9 clear versus coincident edge
    pulses(5, 2, 3);
    idle(10);
    check("R9 preload", count, 5);
    @(negedge clk); evtIn = 1'b1;
    @(negedge clk); wrEn = 1'b1; wrAddr = 2'd2; wrData = 8'h00;
    @(negedge clk); wrEn = 1'b0;
    idle(10);
    check("R9 clear wins", count, 0);
    evtIn = 1'b0;
    idle(10);
    check("R9 no late count", count, 0);

    done = 1'b1;
    report();
  end

endmodule